// File: doc/BRIEF.md
# Pipelined synchronous burst SRAM

This block is a single-port synchronous static memory intended as the data store of a processor's secondary cache. Each word is 18 bits wide, split into two 9-bit byte lanes that can be written independently. Every input except the output enable is captured in a register on the rising clock edge. The access itself takes place on the following edge, and a read result is held in an output register. Reads therefore show one cycle of pipeline latency. The output enable is combinational, so the consumer can turn the data drivers on or off within a cycle.

An access sequence starts when one of two address strobes is asserted: one from the processor and one from the cache controller. The starting address is taken from the address port. Later beats of the same sequence use an internal 2-bit beat counter, which steps only in cycles where the advance input is high. The low two address bits of each beat are the starting low bits XOR the beat count, which gives the interleaved four-beat order used by common processor burst fills. The upper address bits stay fixed. The shared data pins are modelled as separate data-in, data-out and output-enable ports.

The word count is set by the ADDR_W parameter. Its default of 10 gives 1024 words; ADDR_W = 16 gives the full 65,536-word organization.

Top module: `sync_burst_sram`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), rdata_oe_o is low, and no sequence is active until a strobe starts one.
- R2: All inputs except oe_i are sampled on a rising edge. The word read by the access sampled at edge N is visible on rdata_o, with rdata_oe_o high when oe_i is high, from edge N+1.
- R3: rdata_oe_o equals oe_i AND "the last access was a read", with no register on the oe_i path. When oe_i is low, rdata_oe_o is low in the same cycle.
- R4: A strobe (proc_stb_i or ctrl_stb_i) sampled with ce_i high starts a new sequence at addr_i, with beat count 0.
- R5: In a sequence, the address of each beat is the starting address with its bits [1:0] replaced by (start[1:0] XOR count), where count is 2 bits wide. Bits above [1:0] stay fixed, and the count wraps from 3 to 0.
- R6: In a cycle with no strobe and an active sequence, the count increments first if adv_i is high. If adv_i is low, the same address as the previous beat is accessed again.
- R7: we_lo_i writes bits [8:0] and we_hi_i writes bits [17:9] of the addressed word. The lane whose enable is low keeps its old contents.
- R8: If both strobes are high, the processor strobe takes priority. A processor-strobe cycle is always a read, and the write enables are ignored in that cycle.
- R9: A strobe sampled with ce_i low ends any active sequence. No access is made, and rdata_oe_o is low from the next edge.
- R10: A controller-strobe cycle, or a continuation cycle, with either write enable high is a write. rdata_oe_o is low after a write, and a read of the same word in the next access returns the new data.
- R11: Cycles with no strobe and no active sequence make no access and leave rdata_oe_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External start address |
| wdata_i | input | 18 | Write data |
| ce_i | input | 1 | Chip enable, qualifies a strobe |
| proc_stb_i | input | 1 | Processor address strobe (read start) |
| ctrl_stb_i | input | 1 | Controller address strobe (read or write start) |
| adv_i | input | 1 | Step the beat counter |
| we_lo_i | input | 1 | Write enable for bits [8:0] |
| we_hi_i | input | 1 | Write enable for bits [17:9] |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | 18 | Registered read data |
| rdata_oe_o | output | 1 | Data driver enable |

## Verification
A corrupted beat counter or base address shows at the ports two edges after the affected beat is sampled. It appears as a wrong word on rdata_o, because the bench pre-fills every word with a distinct value. A lost or stuck sequence-active state shows up as rdata_oe_o at the wrong level on the very next registered output. A lane write that hits the wrong bits stays hidden until that word is read back, so every lane-write test is followed by a read of the same word within a few cycles.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic             proc_stb;
        logic             ctrl_stb;
        logic             ce;
        logic             adv;
        logic [LANES-1:0] we;
    } req_flags_t;

    // Interleaved beat order: low address bits = start XOR beat count.
    function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] count);
        return start ^ count;
    endfunction

endpackage

// File: rtl/sbs_input_stage.sv
module sbs_input_stage
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [WORD_W-1:0] wdata_d,
    input  req_flags_t        flags_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q,
    output req_flags_t        flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            flags_q <= '0;
        end else begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_q,
    input  req_flags_t        flags_q,
    output acc_kind_e         acc_kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_we
);

    logic              seq_active;
    logic [ADDR_W-1:0] seq_base;
    logic [BEAT_W-1:0] seq_count;
    logic [BEAT_W-1:0] step_count;
    logic              strobe;
    logic              any_we;

    assign strobe     = flags_q.proc_stb | flags_q.ctrl_stb;
    assign any_we     = |flags_q.we;
    assign step_count = flags_q.adv ? seq_count + 1'b1 : seq_count;

    always_comb begin
        acc_kind = ACC_IDLE;
        acc_addr = addr_q;
        acc_we   = '0;
        if (strobe) begin
            if (flags_q.ce) begin
                acc_addr = addr_q;
                if (flags_q.proc_stb || !any_we) begin
                    acc_kind = ACC_READ;
                end else begin
                    acc_kind = ACC_WRITE;
                    acc_we   = flags_q.we;
                end
            end
        end else if (seq_active) begin
            acc_addr = {seq_base[ADDR_W-1:BEAT_W],
                        beat_low(seq_base[BEAT_W-1:0], step_count)};
            if (any_we) begin
                acc_kind = ACC_WRITE;
                acc_we   = flags_q.we;
            end else begin
                acc_kind = ACC_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_active <= 1'b0;
            seq_base   <= '0;
            seq_count  <= '0;
        end else if (strobe) begin
            seq_active <= flags_q.ce;
            seq_base   <= addr_q;
            seq_count  <= '0;
        end else if (seq_active) begin
            seq_count  <= step_count;
        end
    end

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata_q
);

    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= wdata;
        end
        if (rd_en) begin
            rdata_q <= store[addr];
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [17:0]       wdata_i,
    input  logic              ce_i,
    input  logic              proc_stb_i,
    input  logic              ctrl_stb_i,
    input  logic              adv_i,
    input  logic              we_lo_i,
    input  logic              we_hi_i,
    input  logic              oe_i,
    output logic [17:0]       rdata_o,
    output logic              rdata_oe_o
);

    req_flags_t        flags_d;
    req_flags_t        flags_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    acc_kind_e         acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_we;
    logic [WORD_W-1:0] word_q;
    logic              read_valid_q;

    always_comb begin
        flags_d.proc_stb = proc_stb_i;
        flags_d.ctrl_stb = ctrl_stb_i;
        flags_d.ce       = ce_i;
        flags_d.adv      = adv_i;
        flags_d.we       = {we_hi_i, we_lo_i};
    end

    sbs_input_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .addr_d  (addr_i),
        .wdata_d (wdata_i),
        .flags_d (flags_d),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .flags_q (flags_q)
    );

    sbs_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .addr_q   (addr_q),
        .flags_q  (flags_q),
        .acc_kind (acc_kind),
        .acc_addr (acc_addr),
        .acc_we   (acc_we)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        sbs_lane_mem #(.ADDR_W(ADDR_W)) u_mem (
            .clk     (clk),
            .rd_en   (acc_kind == ACC_READ),
            .wr_en   ((acc_kind == ACC_WRITE) && acc_we[ln]),
            .addr    (acc_addr),
            .wdata   (wdata_q[ln*LANE_W +: LANE_W]),
            .rdata_q (word_q[ln*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            read_valid_q <= 1'b0;
        end else begin
            read_valid_q <= (acc_kind == ACC_READ);
        end
    end

    assign rdata_o    = word_q;
    assign rdata_oe_o = oe_i & read_valid_q;

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic ce_i,
    input logic proc_stb_i,
    input logic ctrl_stb_i,
    input logic we_lo_i,
    input logic we_hi_i,
    input logic oe_i,
    input logic rdata_oe_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rdata_oe_o);

    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_i |-> !rdata_oe_o);

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_i && ctrl_stb_i && ce_i && !we_lo_i && !we_hi_i)
        |=> ##1 (rdata_oe_o == oe_i));

    // R8
    proc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_stb_i && ce_i) |=> ##1 (rdata_oe_o == oe_i));

    // R9
    deselect_float_chk: assert property (@(posedge clk) disable iff (rst)
        ((proc_stb_i || ctrl_stb_i) && !ce_i) |=> ##1 !rdata_oe_o);

    // R10
    write_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_i && ctrl_stb_i && ce_i && (we_lo_i || we_hi_i))
        |=> ##1 !rdata_oe_o);

endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_i       (ce_i),
    .proc_stb_i (proc_stb_i),
    .ctrl_stb_i (ctrl_stb_i),
    .we_lo_i    (we_lo_i),
    .we_hi_i    (we_hi_i),
    .oe_i       (oe_i),
    .rdata_oe_o (rdata_oe_o)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [17:0]   wdata_i = '0;
    logic          ce_i = 1'b0, proc_stb_i = 1'b0, ctrl_stb_i = 1'b0, adv_i = 1'b0;
    logic          we_lo_i = 1'b0, we_hi_i = 1'b0, oe_i = 1'b0;
    logic [17:0]   rdata_o;
    logic          rdata_oe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i), .ce_i(ce_i),
        .proc_stb_i(proc_stb_i), .ctrl_stb_i(ctrl_stb_i), .adv_i(adv_i),
        .we_lo_i(we_lo_i), .we_hi_i(we_hi_i), .oe_i(oe_i),
        .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
    );

    // Behavioural reference model
    int unsigned ref_mem [int];
    bit  p_ps, p_cs, p_ce, p_adv, p_wlo, p_whi;
    int  p_addr, p_data;
    bit  m_active;
    int  m_base, m_cnt;
    bit  exp_valid;
    int  exp_data;

    always @(posedge clk) begin
        if (rst) begin
            {p_ps, p_cs, p_ce, p_adv, p_wlo, p_whi} = '0;
            p_addr = 0; p_data = 0;
            m_active = 0; m_base = 0; m_cnt = 0;
            exp_valid = 0;
        end else begin
            bit acc, rd;
            int a;
            acc = 0; rd = 0; a = 0;
            if (p_ps || p_cs) begin
                if (p_ce) begin
                    acc = 1; a = p_addr;
                    rd = p_ps || (!p_wlo && !p_whi);
                    m_active = 1; m_base = p_addr; m_cnt = 0;
                end else begin
                    m_active = 0;
                end
            end else if (m_active) begin
                if (p_adv) m_cnt = (m_cnt + 1) % 4;
                a = (m_base / 4) * 4 + ((m_base % 4) ^ m_cnt);
                rd = !(p_wlo || p_whi);
                acc = 1;
            end
            if (acc && rd) begin
                exp_valid = 1;
                exp_data  = ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
            end else begin
                exp_valid = 0;
                if (acc) begin
                    int w;
                    w = ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
                    if (p_wlo) w = (w & 'h3FE00) | (p_data & 'h1FF);
                    if (p_whi) w = (w & 'h001FF) | (p_data & 'h3FE00);
                    ref_mem[a] = w;
                end
            end
            p_ps = proc_stb_i; p_cs = ctrl_stb_i; p_ce = ce_i; p_adv = adv_i;
            p_wlo = we_lo_i; p_whi = we_hi_i; p_addr = int'(addr_i); p_data = int'(wdata_i);
        end
    end

    task automatic compare(input string tag);
        bit exp_oe;
        exp_oe = oe_i && exp_valid;
        checks++;
        if (rdata_oe_o !== exp_oe) begin
            errors++;
            $display("FAIL %s: rdata_oe_o act %0b exp %0b", tag, rdata_oe_o, exp_oe);
        end else if (exp_oe && (int'(rdata_o) != exp_data)) begin
            errors++;
            $display("FAIL %s: rdata_o act %05h exp %05h", tag, rdata_o, exp_data);
        end
    endtask

    task automatic cyc(input bit ps, input bit cs, input bit ce, input bit adv,
                       input bit wlo, input bit whi, input int a, input int d,
                       input bit oe, input string tag);
        @(negedge clk);
        proc_stb_i = ps; ctrl_stb_i = cs; ce_i = ce; adv_i = adv;
        we_lo_i = wlo; we_hi_i = whi; addr_i = AW'(a); wdata_i = 18'(d); oe_i = oe;
        #1 compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    function automatic int pat(input int a);
        return ((a * 'h1357) ^ 'h2A5A5) & 'h3FFFF;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        oe_i = 1'b1;
        #1 compare("R1");
        idle(3, "R11");

        // R10 / R4: fill words 0..31 with controller-strobe write bursts
        for (int b = 0; b < 32; b += 4) begin
            cyc(0, 1, 1, 0, 1, 1, b, pat(b), 1, "R10");
            for (int k = 1; k < 4; k++)
                cyc(0, 0, 0, 1, 1, 1, 0, pat(b ^ k), 1, "R10");
        end
        idle(2, "R11");

        // R5: processor burst from 5 -> 5,4,7,6 then wrap to 5
        cyc(1, 0, 1, 0, 0, 0, 5, 0, 1, "R4");
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R5");
        // R5: upper bits stay fixed, start at 30
        cyc(1, 0, 1, 0, 0, 0, 30, 0, 1, "R5");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R5");

        // R6: hold without advance, then advance
        cyc(0, 1, 1, 0, 0, 0, 10, 0, 1, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R6");

        // R3: toggle output enable mid-burst
        cyc(1, 0, 1, 0, 0, 0, 17, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R3");

        // R7: lane writes, read back
        cyc(0, 1, 1, 0, 1, 0, 12, 'h3FFFF, 1, "R7");
        cyc(0, 0, 0, 1, 0, 1, 0, 'h00000, 1, "R7");
        cyc(1, 0, 1, 0, 0, 0, 12, 0, 1, "R7");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");

        // R8: both strobes with write enables -> read, no write
        cyc(1, 1, 1, 0, 1, 1, 20, 'h15555, 1, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
        cyc(1, 0, 1, 0, 1, 1, 21, 'h0AAAA, 1, "R8");
        cyc(0, 1, 1, 0, 0, 0, 20, 0, 1, "R8");
        cyc(0, 1, 1, 0, 0, 0, 21, 0, 1, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");

        // R9: deselect stops the sequence
        cyc(1, 0, 1, 0, 0, 0, 8, 0, 1, "R9");
        cyc(1, 0, 0, 0, 0, 0, 9, 0, 1, "R9");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 1, 1, 1, 0, 'h12345, 1, "R9");
        cyc(0, 1, 1, 0, 0, 0, 8, 0, 1, "R9");
        cyc(0, 1, 0, 0, 0, 0, 8, 0, 1, "R9");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R9");
        idle(2, "R11");

        // R10: write inside a read burst, read-after-write
        cyc(0, 1, 1, 0, 0, 0, 24, 0, 1, "R10");
        cyc(0, 0, 0, 1, 1, 1, 0, 'h2BEEF, 1, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");

        // R1: reset mid-burst
        cyc(1, 0, 1, 0, 0, 0, 3, 0, 1, "R1");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 compare("R1");
        idle(3, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule